// File: doc/BRIEF.md
# Four-Channel Serial Wiper Register Port

This block holds the settings of four digital-potentiometer wipers and lets a host load and read them over a slow three-wire serial link. The link has an enable line, a direction line and a serial clock, plus a serial data input and a cascade data output. The block samples all of these inputs with a faster system clock.

While the port is enabled with the direction low, the host writes. Bits are shifted in on rising serial-clock edges. Each completed byte is committed to the next wiper when the eighth clock pulse falls. Wiper 0 is loaded first, then wiper 1, wiper 2 and wiper 3. A frame may stop after any whole byte.

While the port is enabled with the direction high, the stored bytes are shifted out on the data output. While the port is disabled, the data input passes straight through to the data output, so that several ports can be chained. Each wiper value is driven as a parallel 8-bit register. Its 6-bit tap index is driven alongside it.

Top module: `serial_wiper_port`

## Requirements
- R1: After reset every wiper register is 0x00. The port counts as disabled, so `sdo_o` follows `sdi_i`.
- R2: In write mode (enable high, direction low), each rising edge of the serial clock captures `sdi_i`. The byte is assembled most significant bit first.
- R3: A wiper register changes only on the falling serial-clock edge that ends the eighth bit of a byte. After the eighth rising edge, the old value is still present.
- R4: Within one enabled write frame, byte k is loaded into wiper k, for k = 0 to 3. Wiper k sits at bits [8k+7:8k] of `wiper_o`.
- R5: A frame may carry 1, 2, 3 or 4 bytes. Wipers that the frame does not reach keep their earlier values.
- R6: Bytes that follow the fourth byte of a frame change no wiper.
- R7: Dropping the enable clears the bit count and the byte index. A byte that was only partly shifted is therefore discarded. The next frame starts again at wiper 0 with a fresh byte.
- R8: While the synchronized enable is low, `sdo_o` equals `sdi_i` combinationally.
- R9: While enabled in write mode, `sdo_o` is held at 0.
- R10: In read mode (enable high, direction high), `sdo_o` presents wiper 0 bit 7 first. Each falling serial-clock edge advances the output by one bit, through wiper 0 bits 7..0, then wiper 1, and so on to wiper 3 bit 0. After the last bit, `sdo_o` is 0.
- R11: Tap index k on `tap_o[6k+5:6k]` equals the low 6 bits of wiper k.
- R12: All serial inputs are taken through two-flop synchronizers. Serial-clock edges that occur while the enable is low leave every wiper unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Port enable; low disables the port and resets the frame |
| dir_i | input | 1 | Direction: 0 write, 1 read |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Cascade / read-back data output |
| wiper_o | output | 32 | Four 8-bit wiper registers, wiper 0 in the low byte |
| tap_o | output | 24 | Four 6-bit tap indices, wiper 0 in the low bits |

## Verification
The bench stops the serial clock after the eighth rising edge and checks the wiper register there. A design that loads on the rising edge would already show the new byte. The bench drops the enable partway through a byte, then writes a fresh byte. If leftover bit count survives the drop, that byte comes out misaligned. The bench also sends five-byte frames and two-byte frames. These catch an index that wraps around onto wiper 0, and a frame that clears the wipers it did not reach. In read-back, the bench compares every bit before each falling edge and once more after the last bit. This exposes an output that advances on the wrong edge or runs off into stale data.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  typedef enum logic [1:0] {
    SDO_PASS    = 2'd0,
    SDO_INHIBIT = 2'd1,
    SDO_READ    = 2'd2
  } sdo_sel_e;
endpackage

// File: rtl/wpr_sync.sv
module wpr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wpr_frame_ctrl.sv
module wpr_frame_ctrl #(
  parameter  int NUM_WIPERS = 4,
  parameter  int WIPER_W    = 8,
  localparam int IDX_W      = $clog2(NUM_WIPERS + 1),
  localparam int BIT_W      = $clog2(WIPER_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  dir_i,
  input  logic                  sclk_i,
  input  logic                  sdi_i,
  output logic [NUM_WIPERS-1:0] load_o,
  output logic [WIPER_W-1:0]    byte_o,
  output logic [IDX_W-1:0]      rd_idx_o,
  output logic [BIT_W-1:0]      rd_bit_o,
  output logic                  rd_valid_o
);
  localparam int CNT_W = $clog2(WIPER_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIPER_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIPER_W - 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(NUM_WIPERS);

  logic             sclk_q;
  logic             rise, fall;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIPER_W-1:0] shift_q;
  logic [BIT_W-1:0] cnt_lo;

  assign rise = sclk_i & ~sclk_q;
  assign fall = ~sclk_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!dir_i) begin
      if (rise && cnt_q != CNT_FULL) begin
        shift_q <= {shift_q[WIPER_W-2:0], sdi_i};
        cnt_q   <= cnt_q + 1'b1;
      end else if (fall && cnt_q == CNT_FULL) begin
        cnt_q <= '0;
        if (idx_q != IDX_END) idx_q <= idx_q + 1'b1;
      end
    end else if (fall && idx_q != IDX_END) begin
      if (cnt_q >= CNT_LAST) begin
        cnt_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_load
    assign load_o[g] = en_i & ~dir_i & fall & (cnt_q == CNT_FULL) & (idx_q == IDX_W'(g));
  end

  assign cnt_lo     = cnt_q[BIT_W-1:0];
  assign byte_o     = shift_q;
  assign rd_idx_o   = idx_q;
  assign rd_bit_o   = BIT_W'(WIPER_W - 1) - cnt_lo;
  assign rd_valid_o = (idx_q != IDX_END);

  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && idx_q == '0));
  p_load_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|load_o) |-> (!sclk_i && sclk_q && cnt_q == CNT_FULL));
  p_single_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  p_idx_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && idx_q == IDX_END) |=> (idx_q == IDX_END || idx_q == '0));
endmodule

// File: rtl/wpr_wiper_bank.sv
module wpr_wiper_bank #(
  parameter  int NUM_WIPERS = 4,
  parameter  int WIPER_W    = 8,
  parameter  int TAP_W      = 6,
  localparam int IDX_W      = $clog2(NUM_WIPERS + 1),
  localparam int BIT_W      = $clog2(WIPER_W)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_WIPERS-1:0]         load_i,
  input  logic [WIPER_W-1:0]            byte_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  input  logic [BIT_W-1:0]              rd_bit_i,
  input  logic                          rd_valid_i,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiper_o,
  output logic [NUM_WIPERS*TAP_W-1:0]   tap_o,
  output logic                          rd_data_o
);
  logic [WIPER_W-1:0] wq [NUM_WIPERS];

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        wq[g] <= '0;
      else if (load_i[g]) wq[g] <= byte_i;
    end
    assign wiper_o[g*WIPER_W +: WIPER_W] = wq[g];
    assign tap_o[g*TAP_W +: TAP_W]       = wq[g][TAP_W-1:0];

    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i[g] |=> $stable(wq[g]));
  end

  always_comb begin
    rd_data_o = 1'b0;
    if (rd_valid_i) begin
      for (int i = 0; i < NUM_WIPERS; i++) begin
        if (rd_idx_i == IDX_W'(i)) rd_data_o = wq[i][rd_bit_i];
      end
    end
  end
endmodule

// File: rtl/wpr_sdo_mux.sv
module wpr_sdo_mux
  import wpr_pkg::*;
(
  input  logic en_i,
  input  logic dir_i,
  input  logic sdi_raw_i,
  input  logic rd_data_i,
  output logic sdo_o
);
  sdo_sel_e sel;

  always_comb begin
    if (!en_i)      sel = SDO_PASS;
    else if (dir_i) sel = SDO_READ;
    else            sel = SDO_INHIBIT;
  end

  always_comb begin
    unique case (sel)
      SDO_PASS: sdo_o = sdi_raw_i;
      SDO_READ: sdo_o = rd_data_i;
      default:  sdo_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/serial_wiper_port.sv
module serial_wiper_port #(
  parameter  int NUM_WIPERS  = 4,
  parameter  int WIPER_W     = 8,
  parameter  int TAP_W       = 6,
  parameter  int SYNC_STAGES = 2,
  localparam int IDX_W       = $clog2(NUM_WIPERS + 1),
  localparam int BIT_W       = $clog2(WIPER_W)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          dir_i,
  input  logic                          sclk_i,
  input  logic                          sdi_i,
  output logic                          sdo_o,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiper_o,
  output logic [NUM_WIPERS*TAP_W-1:0]   tap_o
);
  logic [3:0]            sync_q;
  logic                  en_s, dir_s, sclk_s, sdi_s;
  logic [NUM_WIPERS-1:0] load;
  logic [WIPER_W-1:0]    byte_w;
  logic [IDX_W-1:0]      rd_idx;
  logic [BIT_W-1:0]      rd_bit;
  logic                  rd_valid, rd_data;

  wpr_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_i, dir_i, sclk_i, sdi_i}),
    .q_o   (sync_q)
  );
  assign {en_s, dir_s, sclk_s, sdi_s} = sync_q;

  wpr_frame_ctrl #(.NUM_WIPERS(NUM_WIPERS), .WIPER_W(WIPER_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_s),
    .dir_i     (dir_s),
    .sclk_i    (sclk_s),
    .sdi_i     (sdi_s),
    .load_o    (load),
    .byte_o    (byte_w),
    .rd_idx_o  (rd_idx),
    .rd_bit_o  (rd_bit),
    .rd_valid_o(rd_valid)
  );

  wpr_wiper_bank #(.NUM_WIPERS(NUM_WIPERS), .WIPER_W(WIPER_W), .TAP_W(TAP_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .byte_i    (byte_w),
    .rd_idx_i  (rd_idx),
    .rd_bit_i  (rd_bit),
    .rd_valid_i(rd_valid),
    .wiper_o   (wiper_o),
    .tap_o     (tap_o),
    .rd_data_o (rd_data)
  );

  wpr_sdo_mux u_mux (
    .en_i     (en_s),
    .dir_i    (dir_s),
    .sdi_raw_i(sdi_i),
    .rd_data_i(rd_data),
    .sdo_o    (sdo_o)
  );

  p_write_inhibit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && !dir_s) |-> !sdo_o);
  p_pass_through_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |-> (sdo_o == sdi_i));
  p_disabled_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> $stable(wiper_o));
  p_read_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && dir_s && !rd_valid) |-> !sdo_o);
endmodule

// File: tb/serial_wiper_port_test.sv
`timescale 1ns/1ps
module serial_wiper_port_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0, dir = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic        sdo;
  logic [31:0] wiper;
  logic [23:0] tap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  serial_wiper_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .dir_i(dir),
    .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .wiper_o(wiper), .tap_o(tap)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: inputs seen two clocks late, edges against the sample before
  typedef struct packed {logic en; logic dir; logic sclk; logic sdi;} smp_t;
  smp_t       hist[$];
  smp_t       cur, prv;
  logic [7:0] m_w [4];
  logic [7:0] m_sh;
  int         m_cnt, m_idx;
  logic [7:0] exp_w [4];

  always @(posedge clk) begin
    if (!rst_ni) begin
      hist = '{smp_t'(0), smp_t'(0), smp_t'(0)};
      for (int i = 0; i < 4; i++) m_w[i] = 8'h00;
      m_sh = 8'h00; m_cnt = 0; m_idx = 0;
    end else begin
      cur = hist[1];
      prv = hist[2];
      if (!cur.en) begin
        m_cnt = 0; m_idx = 0;
      end else if (!cur.dir) begin
        if (cur.sclk && !prv.sclk && m_cnt < 8) begin
          m_sh = {m_sh[6:0], cur.sdi};
          m_cnt++;
        end else if (!cur.sclk && prv.sclk && m_cnt == 8) begin
          if (m_idx < 4) begin
            m_w[m_idx] = m_sh;
            m_idx++;
          end
          m_cnt = 0;
        end
      end else if (!cur.sclk && prv.sclk && m_idx < 4) begin
        if (m_cnt >= 7) begin m_cnt = 0; m_idx++; end
        else m_cnt++;
      end
      hist.push_front('{en, dir, sclk, sdi});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_ni && hist.size() == 3) begin
      logic [31:0] mw;
      logic        e_sdo;
      mw = {m_w[3], m_w[2], m_w[1], m_w[0]};
      chk(wiper == mw, "R4 wiper vs model", wiper, mw);
      chk(tap == {m_w[3][5:0], m_w[2][5:0], m_w[1][5:0], m_w[0][5:0]}, "R11 tap vs model",
          {8'h0, tap}, {8'h0, m_w[3][5:0], m_w[2][5:0], m_w[1][5:0], m_w[0][5:0]});
      if (!hist[1].en) begin
        e_sdo = sdi;
        chk(sdo == e_sdo, "R8 pass-through", {31'h0, sdo}, {31'h0, e_sdo});
      end else if (!hist[1].dir) begin
        e_sdo = 1'b0;
        chk(sdo == e_sdo, "R9 inhibit", {31'h0, sdo}, {31'h0, e_sdo});
      end else begin
        e_sdo = (m_idx < 4) ? m_w[m_idx][7 - m_cnt] : 1'b0;
        chk(sdo == e_sdo, "R10 read bit", {31'h0, sdo}, {31'h0, e_sdo});
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic b);
    sdi = b;  idle(4);
    sclk = 1; idle(4);
    sclk = 0; idle(4);
  endtask

  task automatic send_byte(input logic [7:0] b, input int tgt);
    for (int i = 7; i > 0; i--) pulse(b[i]);
    sdi = b[0]; idle(4);
    sclk = 1;   idle(6);
    if (tgt >= 0)
      chk(wiper[tgt*8 +: 8] == exp_w[tgt], "R3 held after 8th rise", {24'h0, wiper[tgt*8 +: 8]}, {24'h0, exp_w[tgt]});
    sclk = 0;   idle(6);
    if (tgt >= 0) begin
      exp_w[tgt] = b;
      chk(wiper[tgt*8 +: 8] == b, "R2 msb-first byte loaded at fall", {24'h0, wiper[tgt*8 +: 8]}, {24'h0, b});
    end
  endtask

  task automatic open_frame(input logic d);
    dir = d; en = 1; idle(6);
  endtask

  task automatic close_frame();
    en = 0; idle(6);
  endtask

  function automatic logic [31:0] exp_flat();
    return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
  endfunction

  task automatic read_all();
    open_frame(1'b1);
    for (int w = 0; w < 4; w++)
      for (int b = 7; b >= 0; b--) begin
        chk(sdo == exp_w[w][b], "R10 read-back order", {31'h0, sdo}, {31'h0, exp_w[w][b]});
        pulse(1'b0);
      end
    chk(sdo == 1'b0, "R10 zero after last bit", {31'h0, sdo}, 32'h0);
    close_frame();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) exp_w[i] = 8'h00;
    idle(5);
    rst_ni = 1'b1;
    idle(4);
    chk(wiper == 32'h0, "R1 reset wipers", wiper, 32'h0);
    sdi = 1; #1;
    chk(sdo == 1'b1, "R1 reset pass-through", {31'h0, sdo}, 32'h1);
    sdi = 0; idle(2);

    // full frame
    open_frame(1'b0);
    send_byte(8'hA5, 0); send_byte(8'h3C, 1); send_byte(8'hF0, 2); send_byte(8'h81, 3);
    close_frame();
    chk(wiper == 32'h81F03CA5, "R4 four-byte order", wiper, 32'h81F03CA5);
    chk(tap == {6'h01, 6'h30, 6'h3C, 6'h25}, "R11 tap low bits", {8'h0, tap}, {8'h0, 6'h01, 6'h30, 6'h3C, 6'h25});

    // partial frame of two bytes
    open_frame(1'b0);
    send_byte(8'h12, 0); send_byte(8'h7E, 1);
    close_frame();
    chk(wiper == exp_flat(), "R5 unreached wipers kept", wiper, exp_flat());
    chk(wiper[31:16] == 16'h81F0, "R5 upper wipers", {16'h0, wiper[31:16]}, 32'h81F0);

    // five bytes: the last is dropped
    open_frame(1'b0);
    send_byte(8'h01, 0); send_byte(8'h02, 1); send_byte(8'h04, 2); send_byte(8'h08, 3);
    send_byte(8'hFF, -1);
    chk(wiper == 32'h08040201, "R6 extra byte discarded", wiper, 32'h08040201);
    close_frame();

    // sdo inhibited during write
    open_frame(1'b0);
    sdi = 1; idle(3);
    chk(sdo == 1'b0, "R9 inhibited with sdi high", {31'h0, sdo}, 32'h0);
    sdi = 0;
    close_frame();

    // incomplete byte then fresh frame
    open_frame(1'b0);
    pulse(1); pulse(1); pulse(1);
    close_frame();
    chk(wiper == exp_flat(), "R7 partial byte not loaded", wiper, exp_flat());
    open_frame(1'b0);
    send_byte(8'h5A, 0);
    close_frame();
    chk(wiper[7:0] == 8'h5A, "R7 fresh byte aligned", {24'h0, wiper[7:0]}, 32'h5A);

    // clocks while disabled
    for (int i = 0; i < 10; i++) pulse(i[0]);
    chk(wiper == exp_flat(), "R12 disabled clocks ignored", wiper, exp_flat());

    // pass-through
    sdi = 1; #1;
    chk(sdo == 1'b1, "R8 pass high", {31'h0, sdo}, 32'h1);
    sdi = 0; #1;
    chk(sdo == 1'b0, "R8 pass low", {31'h0, sdo}, 32'h0);
    idle(2);

    read_all();

    open_frame(1'b0);
    send_byte(8'hC7, 0); send_byte(8'h6B, 1); send_byte(8'h3F, 2);
    close_frame();
    chk(tap[17:12] == 6'h3F && wiper[31:24] == 8'h08, "R11 tap and R5 kept",
        {8'h0, tap}, {8'h0, 6'h08, 6'h3F, 6'h2B, 6'h07});
    read_all();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule